// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Block

This block emulates the logic core of a small programmable logic device. Thirty-six routed inputs each supply a true and an inverted literal. A programmable fuse matrix ANDs any subset of these literals into 83 product terms. Eighty of the terms are logic terms, grouped in fixed groups of five. Each group is ORed into one of sixteen macrocells. The last three terms are shared control terms: a clock, an initialization and an output enable.

Each macrocell gives either its sum of products directly or a flopped copy of it. A flopped macrocell is clocked by one of four global clocks or by the shared clock term. The shared clock term and the shared initialization term each pass through a configurable inverter. The sixteen macrocell outputs and the output-enable term leave on a single routing-pool port, and that port is also the only feedback path. A user reaches a macrocell's result through the global routing, never through a shortcut inside the block.

The whole configuration loads through a serial shift port that runs while `cfg_en` is high. The fuse matrix and the option bits shift in first-bit-first into a single chain. While loading is in progress, the block holds its outputs low and keeps its macrocells cleared.

Top module: `pla_block`

## Requirements
- R1: Input i supplies two literals. Literal 2i is the true form and literal 2i+1 is the complement. The fuse connecting literal l to term t is configuration stream bit t*72+l, and a 1 connects the literal.
- R2: A product term is the AND of its connected literals. A term with no connected literal evaluates to 1, and a term with both forms of one input connected evaluates to 0.
- R3: Macrocell k takes the OR of logic terms 5k to 5k+4. When its combinational option bit is 1, `rp_out[k]` follows that OR directly, with no clock.
- R4: When its combinational bit is 0, macrocell k loads the OR on the rising edge of its selected clock. A clock select of 0 to 3 picks `gclk[sel]`, and between edges the output holds.
- R5: A clock select of 4 or above picks term 80 XOR the clock-invert bit, which is stream bit 5976.
- R6: Term 81 XOR the init-invert bit (stream bit 5977) is the init signal. While it is 1, every macrocell whose init-enable bit is set holds its flop at 0 asynchronously. The other macrocells are unaffected.
- R7: `rp_oe` equals term 82 whenever configuration is not loading.
- R8: On each `clk` edge while `cfg_en` is 1, the chain shifts `cfg_sdi` in, so stream bit s is the s-th bit sent. Stream bits 0 to 5975 are the fuses. Bits 5976 and 5977 are the invert bits. Macrocell m then takes 5 bits starting at 5978+5m, in this order: combinational, init-enable, clock select MSB to LSB. With `cfg_en` at 0, the configuration does not change.
- R9: While `cfg_en` is 1, `rp_out` and `rp_oe` are 0 and every macrocell flop is cleared.
- R10: After reset the configuration is all zero, so `rp_out` is 0 and `rp_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration load enable |
| cfg_sdi | input | 1 | Serial configuration data |
| gclk | input | 4 | Global clocks for the macrocells |
| rp_in | input | 36 | Routed inputs to the AND array |
| rp_out | output | 16 | Macrocell outputs to the routing pool |
| rp_oe | output | 1 | Shared output-enable term |

## Verification
The assertions sample on `clk` and assume that `rp_in` and `gclk` settle between its edges. They also assume that a shared clock edge never coincides with a change in a flopped macrocell's sum. To keep to this, the stimulus reserves input 35 for the shared clock term and input 34 for the init term, and the random logic terms use only inputs 0 to 33. Input changes, clock pulses and control toggles are always issued as separate steps, never together.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int unsigned NUM_IN   = 36;
  localparam int unsigned NUM_MC   = 16;
  localparam int unsigned CLUSTER  = 5;
  localparam int unsigned NUM_GCLK = 4;
  localparam int unsigned SEL_W    = $clog2(NUM_GCLK + 1);
  localparam int unsigned OPT_W    = 2 + SEL_W;

  typedef struct packed {
    logic             comb;
    logic             init_en;
    logic [SEL_W-1:0] clk_sel;
  } mc_opt_t;
endpackage

// File: rtl/pla_rst_sync.sv
module pla_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
  parameter int unsigned CFG_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             sdi,
  output logic [CFG_W-1:0] cfg_q
);
  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    if (shift_en) cfg_d = {cfg_q[CFG_W-2:0], sdi};
    else          cfg_d = cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end
endmodule

// File: rtl/pla_and_array.sv
module pla_and_array #(
  parameter int unsigned N_IN = 36,
  parameter int unsigned N_PT = 83,
  localparam int unsigned N_LIT  = 2 * N_IN,
  localparam int unsigned FUSE_W = N_LIT * N_PT
) (
  input  logic [N_IN-1:0]   din,
  input  logic [FUSE_W-1:0] fuses,
  output logic [N_PT-1:0]   pt
);
  // literal vector ordered so that literal 0 sits at the top bit
  logic [N_LIT-1:0] lit;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit[N_LIT-1-2*i] = din[i];
    assign lit[N_LIT-2-2*i] = ~din[i];
  end

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    logic [N_LIT-1:0] row;
    assign row   = fuses[FUSE_W-1-t*N_LIT -: N_LIT];
    // unconnected literals are forced to 1 before the wide AND
    assign pt[t] = &(lit | ~row);
  end
endmodule

// File: rtl/pla_macrocell.sv
module pla_macrocell #(
  parameter int unsigned N_GCLK = 4,
  parameter int unsigned SEL_W  = 3
) (
  input  logic [N_GCLK-1:0] gclk,
  input  logic              pt_clk,
  input  logic [SEL_W-1:0]  clk_sel,
  input  logic              comb,
  input  logic              arst,
  input  logic              sum,
  output logic              q_out
);
  logic mc_clk;
  logic flop_d;
  logic flop_q;

  always_comb begin
    mc_clk = pt_clk;
    for (int k = 0; k < int'(N_GCLK); k++) begin
      if (clk_sel == SEL_W'(k)) mc_clk = gclk[k];
    end
  end

  always_comb flop_d = sum;

  always_ff @(posedge mc_clk or posedge arst) begin
    if (arst) flop_q <= 1'b0;
    else      flop_q <= flop_d;
  end

  assign q_out = comb ? sum : flop_q;
endmodule

// File: rtl/pla_block.sv
module pla_block
  import pla_pkg::*;
#(
  parameter int unsigned N_IN = NUM_IN,
  parameter int unsigned N_MC = NUM_MC,
  parameter int unsigned CLU  = CLUSTER
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_en,
  input  logic                cfg_sdi,
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic [N_IN-1:0]     rp_in,
  output logic [N_MC-1:0]     rp_out,
  output logic                rp_oe
);
  localparam int unsigned N_LIT   = 2 * N_IN;
  localparam int unsigned N_LOGIC = N_MC * CLU;
  localparam int unsigned N_PT    = N_LOGIC + 3;
  localparam int unsigned PT_CLK  = N_LOGIC;
  localparam int unsigned PT_INIT = N_LOGIC + 1;
  localparam int unsigned PT_OE   = N_LOGIC + 2;
  localparam int unsigned FUSE_W  = N_LIT * N_PT;
  localparam int unsigned CFG_W   = FUSE_W + 2 + N_MC * OPT_W;

  logic             rst_sync_n;
  logic [CFG_W-1:0] cfg_q;
  logic [N_PT-1:0]  pt;
  logic             clk_inv;
  logic             init_inv;
  logic             pt_clk;
  logic             init_act;
  logic [N_MC-1:0]  mc_comb;
  logic [N_MC-1:0]  mc_ien;
  logic [N_MC-1:0]  mc_q;

  pla_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pla_cfg_chain #(.CFG_W(CFG_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shift_en (cfg_en),
    .sdi      (cfg_sdi),
    .cfg_q    (cfg_q)
  );

  pla_and_array #(.N_IN(N_IN), .N_PT(N_PT)) u_arr (
    .din   (rp_in),
    .fuses (cfg_q[CFG_W-1 -: FUSE_W]),
    .pt    (pt)
  );

  assign clk_inv  = cfg_q[CFG_W-1-FUSE_W];
  assign init_inv = cfg_q[CFG_W-2-FUSE_W];
  assign pt_clk   = pt[PT_CLK]  ^ clk_inv;
  assign init_act = pt[PT_INIT] ^ init_inv;

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    mc_opt_t opt;
    logic    sum;
    logic    arst;

    assign opt        = cfg_q[CFG_W-1-(FUSE_W+2+m*OPT_W) -: OPT_W];
    assign sum        = |pt[m*CLU +: CLU];
    assign arst       = ~rst_sync_n | cfg_en | (init_act & opt.init_en);
    assign mc_comb[m] = opt.comb;
    assign mc_ien[m]  = opt.init_en;

    pla_macrocell #(.N_GCLK(NUM_GCLK), .SEL_W(SEL_W)) u_mc (
      .gclk    (gclk),
      .pt_clk  (pt_clk),
      .clk_sel (opt.clk_sel),
      .comb    (opt.comb),
      .arst    (arst),
      .sum     (sum),
      .q_out   (mc_q[m])
    );
  end

  assign rp_out = cfg_en ? '0 : mc_q;
  assign rp_oe  = ~cfg_en & pt[PT_OE];
endmodule

// File: rtl/pla_block_chk.sv
module pla_block_chk #(
  parameter int unsigned N_MC  = 16,
  parameter int unsigned N_PT  = 83,
  parameter int unsigned CLU   = 5,
  parameter int unsigned CFG_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic             cfg_sdi,
  input logic [CFG_W-1:0] cfg_q,
  input logic [N_PT-1:0]  pt,
  input logic             init_act,
  input logic [N_MC-1:0]  mc_comb,
  input logic [N_MC-1:0]  mc_ien,
  input logic [N_MC-1:0]  rp_out,
  input logic             rp_oe
);
  AST_LOAD_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> (rp_out == '0) && !rp_oe);  // R9

  AST_CHAIN_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && $past(cfg_en)) |=> cfg_q[0] == $past(cfg_sdi));  // R8

  AST_CHAIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_q));  // R8

  for (genvar m = 0; m < N_MC; m++) begin : g_chk
    AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (init_act && mc_ien[m] && !mc_comb[m]) |-> !rp_out[m]);  // R6

    AST_COMB_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && mc_comb[m]) |-> rp_out[m] == |pt[m*CLU +: CLU]);  // R3
  end
endmodule

bind pla_block pla_block_chk #(
  .N_MC(N_MC), .N_PT(N_PT), .CLU(CLU), .CFG_W(CFG_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_en   (cfg_en),
  .cfg_sdi  (cfg_sdi),
  .cfg_q    (cfg_q),
  .pt       (pt),
  .init_act (init_act),
  .mc_comb  (mc_comb),
  .mc_ien   (mc_ien),
  .rp_out   (rp_out),
  .rp_oe    (rp_oe)
);

// File: tb/sim_pla_block.sv
`timescale 1ns/1ps
module sim_pla_block;
  import pla_pkg::*;

  localparam int NI  = 36;
  localparam int NM  = 16;
  localparam int NL  = 72;
  localparam int NPT = 83;
  localparam int FW  = NL * NPT;
  localparam int CW  = FW + 2 + NM * OPT_W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_en;
  logic          cfg_sdi;
  logic [3:0]    gclk;
  logic [NI-1:0] rp_in;
  logic [NM-1:0] rp_out;
  logic          rp_oe;

  pla_block u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_sdi(cfg_sdi),
    .gclk(gclk), .rp_in(rp_in), .rp_out(rp_out), .rp_oe(rp_oe)
  );

  always #5 clk = ~clk;

  // bench model of the configuration and macrocell state
  bit fz [NPT][NL];
  bit m_cinv, m_iinv;
  bit m_comb [NM];
  bit m_ien  [NM];
  int m_sel  [NM];
  bit st     [NM];
  int n_chk = 0;
  int n_bad = 0;

  function automatic bit f_pt(int t, logic [NI-1:0] x);
    bit r = 1'b1;
    for (int l = 0; l < NL; l++)
      if (fz[t][l]) r &= (l % 2 == 0) ? x[l/2] : ~x[l/2];
    return r;
  endfunction

  function automatic bit f_sum(int m, logic [NI-1:0] x);
    bit r = 1'b0;
    for (int j = 0; j < 5; j++) r |= f_pt(m*5 + j, x);
    return r;
  endfunction

  function automatic bit f_stream(int s);
    int k, m;
    if (s < FW) return fz[s / NL][s % NL];
    s -= FW;
    if (s == 0) return m_cinv;
    if (s == 1) return m_iinv;
    s -= 2;
    m = s / OPT_W;
    k = s % OPT_W;
    if (k == 0) return m_comb[m];
    if (k == 1) return m_ien[m];
    return m_sel[m][SEL_W-1-(k-2)];
  endfunction

  function automatic logic [NM-1:0] f_exp();
    logic [NM-1:0] e;
    for (int m = 0; m < NM; m++) e[m] = m_comb[m] ? f_sum(m, rp_in) : st[m];
    return e;
  endfunction

  task automatic chk(input string req, input logic [NM-1:0] act, input logic [NM-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: rp_out=%h expected %h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic model_init();
    bit ia = f_pt(81, rp_in) ^ m_iinv;
    for (int m = 0; m < NM; m++) if (ia && m_ien[m]) st[m] = 1'b0;
  endtask

  task automatic check_all(input string req);
    chk(req, rp_out, f_exp());
    chk1("R7 oe term", rp_oe, f_pt(82, rp_in));
  endtask

  task automatic load_cfg();
    @(negedge clk);
    cfg_en = 1'b1;
    for (int s = 0; s < CW; s++) begin
      cfg_sdi = f_stream(s);
      @(negedge clk);
      if (s == 100) begin
        chk("R9 outputs low while loading", rp_out, '0);
        chk1("R9 oe low while loading", rp_oe, 1'b0);
      end
    end
    cfg_en = 1'b0;
    for (int m = 0; m < NM; m++) st[m] = 1'b0;
    #1;
    model_init();
  endtask

  task automatic set_in(input logic [NI-1:0] nv);
    bit old_c, new_c, ia;
    old_c = f_pt(80, rp_in) ^ m_cinv;
    rp_in = nv;
    #1;
    new_c = f_pt(80, rp_in) ^ m_cinv;
    ia    = f_pt(81, rp_in) ^ m_iinv;
    if (!old_c && new_c)
      for (int m = 0; m < NM; m++)
        if (m_sel[m] >= 4 && !(ia && m_ien[m])) st[m] = f_sum(m, rp_in);
    model_init();
  endtask

  task automatic pulse(input int k);
    bit ia = f_pt(81, rp_in) ^ m_iinv;
    gclk[k] = 1'b1;
    #1;
    for (int m = 0; m < NM; m++)
      if (m_sel[m] == k && !(ia && m_ien[m])) st[m] = f_sum(m, rp_in);
    #1;
    check_all("R4 global clock capture");
    gclk[k] = 1'b0;
    #1;
  endtask

  function automatic logic [NI-1:0] rnd_in(logic [NI-1:0] cur);
    logic [63:0] r = {$urandom(), $urandom()};
    return {cur[35:34], r[33:0]};
  endfunction

  task automatic clear_fz();
    for (int t = 0; t < NPT; t++)
      for (int l = 0; l < NL; l++) fz[t][l] = 1'b0;
  endtask

  task automatic rand_cfg(input bit all_comb);
    int u;
    clear_fz();
    for (int t = 0; t < 80; t++) begin
      int n = 1 + $urandom % 3;
      for (int j = 0; j < n; j++) begin
        u = $urandom % 34;
        fz[t][2*u + ($urandom % 2)] = 1'b1;
      end
      if ($urandom % 10 == 0) begin fz[t][0] = 1'b1; fz[t][1] = 1'b1; end
    end
    fz[80][70] = 1'b1;  // shared clock term: input 35 true
    fz[81][68] = 1'b1;  // shared init term: input 34 true
    u = $urandom % 34;
    fz[82][2*u + ($urandom % 2)] = 1'b1;
    m_cinv = 1'($urandom % 2);
    m_iinv = 1'($urandom % 2);
    for (int m = 0; m < NM; m++) begin
      m_comb[m] = all_comb;
      m_ien[m]  = 1'($urandom % 2);
      m_sel[m]  = $urandom % 5;
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(150000 * 10);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0a11));
    rst_n = 1'b0; cfg_en = 1'b0; cfg_sdi = 1'b0; gclk = '0; rp_in = '0;
    clear_fz();
    m_cinv = 0; m_iinv = 0;
    for (int m = 0; m < NM; m++) begin
      m_comb[m] = 0; m_ien[m] = 0; m_sel[m] = 0; st[m] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    chk("R10 outputs after reset", rp_out, '0);
    chk1("R10 oe after reset", rp_oe, 1'b1);

    // directed: literal mapping and term corner cases
    clear_fz();
    for (int t = 0; t < 80; t++) begin fz[t][2] = 1'b1; fz[t][3] = 1'b1; end
    fz[0][2] = 1'b0; fz[0][3] = 1'b0;            // empty term -> 1
    fz[5][2] = 1'b0; fz[5][3] = 1'b0;
    fz[5][6] = 1'b1;  fz[5][11] = 1'b1;          // in3 & ~in5
    fz[10][2] = 1'b0; fz[10][3] = 1'b0;
    fz[10][0] = 1'b1; fz[10][1] = 1'b1;          // in0 & ~in0 -> 0
    fz[82][15] = 1'b1;                           // oe = ~in7
    m_cinv = 0; m_iinv = 0;
    for (int m = 0; m < NM; m++) begin m_comb[m] = 1; m_ien[m] = 0; m_sel[m] = 0; end
    load_cfg();
    set_in(36'h0_0000_0008);                     // in3=1 in5=0 in7=0
    chk1("R2 empty term gives 1", rp_out[0], 1'b1);
    chk1("R1 true/complement literals", rp_out[1], 1'b1);
    chk1("R2 contradiction gives 0", rp_out[2], 1'b0);
    chk1("R7 oe from complement literal", rp_oe, 1'b1);
    set_in(36'h0_0000_00A9);                     // in3=1 in5=1 in7=1 in0=1
    chk1("R1 complement literal blocks", rp_out[1], 1'b0);
    chk1("R2 contradiction holds 0", rp_out[2], 1'b0);
    chk1("R7 oe follows term", rp_oe, 1'b0);
    check_all("R3 directed cluster sums");

    // R8: configuration frozen while cfg_en is low
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cfg_sdi = ~cfg_sdi;
    end
    #1;
    check_all("R8 config unchanged without cfg_en");

    // random combinational configurations
    for (int c = 0; c < 3; c++) begin
      rand_cfg(1'b1);
      load_cfg();
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        set_in(rnd_in(rp_in));
        check_all("R3 combinational sums");
      end
    end

    // random registered configurations
    for (int c = 0; c < 4; c++) begin
      rand_cfg(1'b0);
      load_cfg();
      check_all("R9 cleared after load");
      for (int i = 0; i < 40; i++) begin
        int act = $urandom % 4;
        logic [NI-1:0] nv;
        @(negedge clk);
        case (act)
          0: begin set_in(rnd_in(rp_in)); check_all("R4 registered output holds"); end
          1: pulse($urandom % 4);
          2: begin nv = rp_in; nv[35] = ~nv[35]; set_in(nv); check_all("R5 shared clock term"); end
          default: begin nv = rp_in; nv[34] = ~nv[34]; set_in(nv); check_all("R6 shared init term"); end
        endcase
      end
    end

    finish_run();
  end
endmodule